// File: doc/BRIEF.md
# Lane Event Counter

The block counts one chosen event pulse out of a bank of per-lane event strobes. Strobes are arranged by group, event index within the group, and lane. A single control word picks the group, the event and the lane. The same control word carries short command codes that start counting, stop counting, or zero the count. A 32-bit count is read back through a separate data register.

The register port is word-addressed. It has a write strobe, a byte offset and a combinational read path. The control register sits at offset 0x8 and the data register at offset 0xC. Software normally programs a selection together with a clear command, turns counting on, and reads the data register later. It may move the selection to a different lane or event at any time without losing the running total.

Top module: `lane_evt_counter`

## Requirements
- R1: A read at offset 0x8 returns the stored selection (group in bits 27:24, event in bits 23:16, lane in bits 11:8) and the status in bit 7, with all other bits 0. A read at offset 0xC returns the count. A read at any other offset returns 0.
- R2: While counting is on, the count rises by one at each clock edge on which the selected strobe is high. Strobes that are not selected have no effect. The strobe index is ((group*EVENTS)+event)*LANES+lane.
- R3: An enable field (control bits 4:2) of 3 turns counting on, and a value of 1 turns it off. Either change takes effect from the clock edge after the write edge. While counting is off the count holds.
- R4: A clear field (control bits 1:0) of 1 sets the count to 0 at the write edge.
- R5: Enable field values other than 1 and 3, including 0, leave the counting state unchanged. Clear field values other than 1 leave the count unchanged.
- R6: Writing a new selection never changes the count by itself.
- R7: Status bit 7 of the control register reads 1 while counting is on and 0 while it is off. Writes to this bit are ignored.
- R8: When a single write carries clear 1 and enable 3, the count is 0 after the write edge, even if the selected strobe is high on that edge. Counting then starts on the following edge.
- R9: A selection whose group, event or lane lies outside the configured bank matches no strobe, so the count holds.
- R10: After reset, counting is off, the count is 0 and the selection is all zero.
- R11: Writes to offset 0xC are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| evt_i | input | GROUPS*EVENTS*LANES | Per-lane event strobes |

## Verification
A wrong internal state shows up at the data register or at status bit 7 within one cycle of the edge that caused it. The counter, the enable flag and the selection are each one register deep, and the read path is combinational. The bench therefore reads the count at the negative edge right after each write, and again after each burst of strobes. A stale enable, a lost clear or a misrouted strobe index shows as an off-by-one or off-by-burst count at the next read. The same-word clear-and-enable ordering is checked edge by edge while the selected strobe is held high.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CTRL_OFF = 8'h08;
  localparam int unsigned DATA_OFF = 8'h0C;

  localparam int unsigned GRP_LSB  = 24;
  localparam int unsigned EVT_LSB  = 16;
  localparam int unsigned LANE_LSB = 8;
  localparam int unsigned STAT_BIT = 7;
  localparam int unsigned EN_LSB   = 2;
  localparam int unsigned CLR_LSB  = 0;

  localparam logic [2:0] EN_ON   = 3'd3;
  localparam logic [2:0] EN_OFF  = 3'd1;
  localparam logic [1:0] CLR_CMD = 2'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } sel_t;
endpackage

// File: rtl/lec_ctrl_reg.sv
module lec_ctrl_reg
  import lec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sel_t              sel_o,
  output logic              en_o,
  output logic              clr_o
);
  logic [2:0] en_code;
  logic [1:0] clr_code;
  sel_t       sel_q;
  logic       en_q;

  assign en_code  = wdata_i[EN_LSB +: 3];
  assign clr_code = wdata_i[CLR_LSB +: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_i) begin
      sel_q.grp  <= wdata_i[GRP_LSB +: 4];
      sel_q.evt  <= wdata_i[EVT_LSB +: 8];
      sel_q.lane <= wdata_i[LANE_LSB +: 4];
      if (en_code == EN_ON)       en_q <= 1'b1;
      else if (en_code == EN_OFF) en_q <= 1'b0;
    end
  end

  assign sel_o = sel_q;
  assign en_o  = en_q;
  assign clr_o = wr_i && (clr_code == CLR_CMD);

  AST_EN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (wdata_i[EN_LSB +: 3] == 3'd3) |=> en_o); // R3
  AST_EN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (wdata_i[EN_LSB +: 3] == 3'd3 || wdata_i[EN_LSB +: 3] == 3'd1)) |=> $stable(en_o)); // R5
endmodule

// File: rtl/lec_evt_mux.sv
module lec_evt_mux
  import lec_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int EVENTS = 8,
  parameter int LANES  = 4,
  localparam int NUM_GE  = GROUPS * EVENTS,
  localparam int NUM_EVT = NUM_GE * LANES,
  localparam int LANE_IW = (LANES  > 1) ? $clog2(LANES)  : 1,
  localparam int GE_IW   = (NUM_GE > 1) ? $clog2(NUM_GE) : 1
) (
  input  sel_t               sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  logic [NUM_GE-1:0] per_ge;
  logic [LANE_IW-1:0] lane_idx;
  logic [GE_IW-1:0]   ge_idx;
  logic               in_range;

  assign lane_idx = LANE_IW'(sel_i.lane);
  assign ge_idx   = GE_IW'(int'(sel_i.grp) * EVENTS + int'(sel_i.evt));
  assign in_range = (int'(sel_i.grp) < GROUPS) && (int'(sel_i.evt) < EVENTS)
                 && (int'(sel_i.lane) < LANES);

  // lane pick inside every group/event slot
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar e = 0; e < EVENTS; e++) begin : g_evt
      localparam int BASE = (g * EVENTS + e) * LANES;
      logic [LANES-1:0] lanes;
      assign lanes = evt_i[BASE +: LANES];
      assign per_ge[g*EVENTS+e] = in_range && lanes[lane_idx];
    end
  end

  assign hit_o = in_range && per_ge[ge_idx];
endmodule

// File: rtl/lec_count.sv
module lec_count
  import lec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [DATA_W-1:0] cnt_o
);
  logic [DATA_W-1:0] cnt_q;

  // clear wins over a same-edge increment; wraps modulo 2^DATA_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !inc_i |=> $stable(cnt_o)); // R3
endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
  import lec_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int EVENTS = 8,
  parameter int LANES  = 4,
  parameter int ADDR_W = 8,
  localparam int NUM_EVT = GROUPS * EVENTS * LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i
);
  sel_t              sel;
  logic              en, clr, hit, ctrl_wr;
  logic [DATA_W-1:0] cnt;
  logic              is_ctrl, is_data;

  assign is_ctrl = (reg_addr_i == ADDR_W'(CTRL_OFF));
  assign is_data = (reg_addr_i == ADDR_W'(DATA_OFF));
  assign ctrl_wr = reg_we_i && is_ctrl;

  lec_ctrl_reg u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl_wr),
    .wdata_i(reg_wdata_i),
    .sel_o  (sel),
    .en_o   (en),
    .clr_o  (clr)
  );

  lec_evt_mux #(.GROUPS(GROUPS), .EVENTS(EVENTS), .LANES(LANES)) u_mux (
    .sel_i(sel),
    .evt_i(evt_i),
    .hit_o(hit)
  );

  lec_count u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (en && hit),
    .cnt_o  (cnt)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (is_ctrl) begin
      reg_rdata_o[GRP_LSB +: 4]  = sel.grp;
      reg_rdata_o[EVT_LSB +: 8]  = sel.evt;
      reg_rdata_o[LANE_LSB +: 4] = sel.lane;
      reg_rdata_o[STAT_BIT]      = en;
    end else if (is_data) begin
      reg_rdata_o = cnt;
    end
  end

  AST_SEL_KEEPS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && (reg_wdata_i[1:0] != 2'd1) && !(en && hit) |=> $stable(cnt)); // R6
endmodule

// File: tb/lane_evt_counter_bench.sv
module lane_evt_counter_bench;
  localparam int CLK_P = 10;
  localparam int NG = 8, NE = 8, NL = 4;
  localparam int NEVT = NG * NE * NL;

  logic            clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wdata = '0, rdata;
  logic [NEVT-1:0] evt = '0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lane_evt_counter #(.GROUPS(NG), .EVENTS(NE), .LANES(NL), .ADDR_W(8)) u_lane_evt_counter (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt)
  );

  function automatic logic [31:0] mk(int g, int e, int l, int en, int clr);
    return (32'(g) << 24) | (32'(e) << 16) | (32'(l) << 8) | (32'(en) << 2) | 32'(clr);
  endfunction

  function automatic int ix(int g, int e, int l);
    return (g * NE + e) * NL + l;
  endfunction

  typedef struct packed {
    logic [31:0] ctrl;
    logic [15:0] idx;   // 16'hFFFF drives every strobe
    logic [7:0]  n;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{mk(1,2,3,3,1), 16'(ix(1,2,3)), 8'd5, 32'd5,  "R2 "},
    '{mk(1,2,3,0,0), 16'(ix(1,2,2)), 8'd4, 32'd5,  "R2 "},
    '{mk(2,0,1,0,0), 16'(ix(2,0,1)), 8'd3, 32'd8,  "R6 "},
    '{mk(2,0,1,1,0), 16'(ix(2,0,1)), 8'd4, 32'd8,  "R3 "},
    '{mk(2,0,1,2,0), 16'(ix(2,0,1)), 8'd2, 32'd8,  "R5 "},
    '{mk(2,0,1,3,0), 16'(ix(2,0,1)), 8'd2, 32'd10, "R3 "},
    '{mk(2,0,1,0,2), 16'(ix(2,0,1)), 8'd0, 32'd10, "R5 "},
    '{mk(2,0,1,0,1), 16'(ix(2,0,1)), 8'd1, 32'd1,  "R4 "},
    '{mk(9,0,0,0,0), 16'hFFFF,       8'd3, 32'd1,  "R9 "}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(rdata, exp, req);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(8'h0C, 32'd0, "R10");
    rd(8'h08, 32'd0, "R10");
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      wr(8'h08, VECS[i].ctrl);
      if (VECS[i].idx == 16'hFFFF) evt = '1;
      else if (VECS[i].n != 0) evt[VECS[i].idx] = 1'b1;
      for (int k = 0; k < int'(VECS[i].n); k++) @(negedge clk);
      evt = '0;
      rd(8'h0C, VECS[i].exp, string'(VECS[i].tag));
    end

    // R1 R7: selection readback with status on
    rd(8'h08, 32'h0900_0080, "R7");
    // R11: data register is read-only
    wr(8'h0C, 32'h0000_1234);
    rd(8'h0C, 32'd1, "R11");
    // R1: unmapped offset
    rd(8'h10, 32'd0, "R1");

    // R8: clear and enable in one word with the strobe held high
    wr(8'h08, mk(0,1,0,1,0));
    rd(8'h08, 32'h0001_0000, "R1");
    evt[ix(0,1,0)] = 1'b1;
    wr(8'h08, mk(0,1,0,3,1));
    rd(8'h0C, 32'd0, "R8");
    @(negedge clk);
    rd(8'h0C, 32'd1, "R8");
    rd(8'h08, 32'h0001_0080, "R7");
    wr(8'h08, mk(0,1,0,1,0));
    rd(8'h0C, 32'd2, "R3");
    @(negedge clk);
    rd(8'h0C, 32'd2, "R3");
    rd(8'h08, 32'h0001_0000, "R7");
    evt = '0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule